// File: doc/BRIEF.md
# Exception and Control-Register Unit

This unit keeps the processor's status word, two shadow copies of it (one for
exceptions, one for breakpoints) and the two matching return addresses. The
pipeline presents one event per cycle on a small code: trap, break, exception
return, break return or control write. The unit updates its registers at the
clock edge and, for the four flow-changing events, raises a one-cycle redirect
strobe together with the new program counter.

Trap and break each save status into their own shadow and record `PC + 4` in
their own return-address register. On entry, both clear the interrupt-enable
and user-mode bits, and each jumps to a fixed handler address given as a
parameter. Exception return and break return restore status from the matching
shadow and jump to the matching return address. Because the two paths are
separate, a break taken inside an exception handler unwinds correctly.

Software reaches the three status-type registers by index. A read is
combinational: the selected register appears zero-extended on the read port. A
write is an event: it stores the low defined bits of the operand, and the
undefined upper bits are always held at zero.

Top module: `exc_ctl_unit`

## Requirements
- R1: After a synchronous active-low reset, status, exception-status and break-status all read 0, and the redirect strobe is low.
- R2: Trap (event code 1) copies status into exception-status. It clears status bit 0 (interrupt enable) and bit 1 (user mode), stores `pc_i + 4` as the exception return address, and redirects to `HANDLER_PC`.
- R3: Break (event code 2) copies status into break-status. It clears status bits 0 and 1, stores `pc_i + 4` as the break return address, and redirects to `BREAK_PC`.
- R4: Exception return (event code 3) loads status from exception-status and redirects to the stored exception return address.
- R5: Break return (event code 4) loads status from break-status and redirects to the stored break return address.
- R6: `rd_data_o` combinationally shows the register selected by `ctl_idx_i` (0 status, 1 exception-status, 2 break-status), zero-extended. Any other index reads 0.
- R7: Control write (event code 5) stores `wr_data_i[1:0]` into the register at `ctl_idx_i` (index 0, 1 or 2). Upper operand bits are discarded, and a write to any other index changes nothing.
- R8: `redirect_o` is high for exactly the one cycle after a trap, break, exception return or break return is accepted. It is low after any other event.
- R9: In a nested sequence (trap, break, break return, exception return), each return restores the status that was live when its own entry event was taken.
- R10: Event codes 0, 6 and 7 change no register and raise no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 3 | Event code: 0 none, 1 trap, 2 break, 3 exception return, 4 break return, 5 control write |
| pc_i | input | AW | PC of the instruction raising the event |
| wr_data_i | input | DW | Operand for a control write |
| ctl_idx_i | input | IDXW | Control register index for reads and writes |
| rd_data_o | output | DW | Selected control register, zero-extended |
| status_o | output | 2 | Live status: bit 0 interrupt enable, bit 1 user mode |
| redirect_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | AW | Target PC while `redirect_o` is high |

## Verification
Every register change and every redirect is due one clock edge after the event is presented. The bench therefore drives each event just after a rising edge, waits for the next rising edge, and samples 1 ns later. Control reads are combinational, so the bench steps `ctl_idx_i` through several indices and samples each after a 1 ns settle, always within the same cycle. Return addresses are not readable, so they are checked through the redirect PC of the matching return, one edge after that return is issued.

// File: rtl/exc_ctl_pkg.sv
// Shared definitions for the exception and control-register unit.
// Assumes a two-bit status word: bit 0 interrupt enable, bit 1 user mode.
package exc_ctl_pkg;
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_TRAP  = 3'd1,
        EV_BRK   = 3'd2,
        EV_ERET  = 3'd3,
        EV_BRET  = 3'd4,
        EV_WRCTL = 3'd5
    } exc_evt_e;

    localparam int unsigned STAT_W     = 2;
    localparam int unsigned BIT_IE     = 0;
    localparam int unsigned BIT_USER   = 1;
    localparam int unsigned IDX_STATUS = 0;
    localparam int unsigned IDX_ESTAT  = 1;
    localparam int unsigned IDX_BSTAT  = 2;
    localparam int unsigned NUM_CTL    = 3;

    // Bits cleared in status on trap or break entry.
    localparam logic [STAT_W-1:0] ENTRY_CLR =
        STAT_W'((1 << BIT_IE) | (1 << BIT_USER));
endpackage

// File: rtl/exc_status_regs.sv
// Status, exception-status and break-status registers.
// Assumes at most one of the event flags is high in a cycle.
module exc_status_regs
    import exc_ctl_pkg::*;
#(
    parameter int unsigned IDXW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_trap,
    input  logic              is_brk,
    input  logic              is_eret,
    input  logic              is_bret,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [STAT_W-1:0] wr_val,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] estat_q,
    output logic [STAT_W-1:0] bstat_q
);
    logic wr_stat, wr_estat, wr_bstat;

    // Decode which register a control write targets.
    always_comb begin
        wr_stat  = wr_en && (wr_idx == IDXW'(IDX_STATUS));
        wr_estat = wr_en && (wr_idx == IDXW'(IDX_ESTAT));
        wr_bstat = wr_en && (wr_idx == IDXW'(IDX_BSTAT));
    end

    // Live status: cleared on entry, restored on return, or written.
    always_ff @(posedge clk) begin
        if (!rst_n)                  stat_q <= '0;
        else if (is_trap || is_brk)  stat_q <= stat_q & ~ENTRY_CLR;
        else if (is_eret)            stat_q <= estat_q;
        else if (is_bret)            stat_q <= bstat_q;
        else if (wr_stat)            stat_q <= wr_val;
    end

    // Exception shadow: captures status on trap, or takes a write.
    always_ff @(posedge clk) begin
        if (!rst_n)         estat_q <= '0;
        else if (is_trap)   estat_q <= stat_q;
        else if (wr_estat)  estat_q <= wr_val;
    end

    // Break shadow: captures status on break, or takes a write.
    always_ff @(posedge clk) begin
        if (!rst_n)         bstat_q <= '0;
        else if (is_brk)    bstat_q <= stat_q;
        else if (wr_bstat)  bstat_q <= wr_val;
    end
endmodule

// File: rtl/exc_return_regs.sv
// Return-address registers for trap and break entry.
// Assumes pc_i is valid in the cycle the entry event is presented.
module exc_return_regs #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_trap,
    input  logic          is_brk,
    input  logic [AW-1:0] pc_i,
    output logic [AW-1:0] ea_q,
    output logic [AW-1:0] ba_q
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    logic [AW-1:0] next_pc;

    // Address of the instruction after the one raising the event.
    always_comb next_pc = pc_i + INSN_BYTES;

    // Exception return address, loaded on trap.
    always_ff @(posedge clk) begin
        if (!rst_n)        ea_q <= '0;
        else if (is_trap)  ea_q <= next_pc;
    end

    // Break return address, loaded on break.
    always_ff @(posedge clk) begin
        if (!rst_n)       ba_q <= '0;
        else if (is_brk)  ba_q <= next_pc;
    end
endmodule

// File: rtl/exc_redirect.sv
// Registered redirect strobe and target selection.
// Assumes ea_q and ba_q hold the pre-edge return addresses.
module exc_redirect #(
    parameter int unsigned   AW         = 32,
    parameter logic [AW-1:0] HANDLER_PC = '0,
    parameter logic [AW-1:0] BREAK_PC   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_trap,
    input  logic          is_brk,
    input  logic          is_eret,
    input  logic          is_bret,
    input  logic [AW-1:0] ea_q,
    input  logic [AW-1:0] ba_q,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o
);
    logic [AW-1:0] target;

    // Pick the target for whichever flow event is present.
    always_comb begin
        target = '0;
        if (is_trap)       target = HANDLER_PC;
        else if (is_brk)   target = BREAK_PC;
        else if (is_eret)  target = ea_q;
        else if (is_bret)  target = ba_q;
    end

    // Register the strobe and the target for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
        end else begin
            redirect_o    <= is_trap || is_brk || is_eret || is_bret;
            redirect_pc_o <= target;
        end
    end
endmodule

// File: rtl/exc_ctl_read.sv
// Combinational control-register read port with zero extension.
// Assumes indices at or above NUM_CTL are unmapped and read zero.
module exc_ctl_read
    import exc_ctl_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned IDXW = 5
) (
    input  logic [IDXW-1:0]   idx,
    input  logic [STAT_W-1:0] stat_q,
    input  logic [STAT_W-1:0] estat_q,
    input  logic [STAT_W-1:0] bstat_q,
    output logic [DW-1:0]     rd_data
);
    logic [STAT_W-1:0] raw   [NUM_CTL];
    logic [DW-1:0]     view  [NUM_CTL];
    logic [NUM_CTL-1:0] hit;

    // Gather the mapped registers in index order.
    always_comb begin
        raw[IDX_STATUS] = stat_q;
        raw[IDX_ESTAT]  = estat_q;
        raw[IDX_BSTAT]  = bstat_q;
    end

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_slot
        // Zero-extend each slot and decode its index match.
        always_comb begin
            view[g] = DW'(raw[g]);
            hit[g]  = (idx == IDXW'(g));
        end
    end

    // AND-OR mux; no hit yields zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTL; i++)
            rd_data = rd_data | (view[i] & {DW{hit[i]}});
    end
endmodule

// File: rtl/exc_ctl_unit.sv
// Top of the exception and control-register unit.
// Decodes one event per cycle and drives the register and redirect logic.
// Assumes events arrive one per cycle with pc_i valid alongside.
module exc_ctl_unit
    import exc_ctl_pkg::*;
#(
    parameter int unsigned   DW         = 32,
    parameter int unsigned   AW         = 32,
    parameter int unsigned   IDXW       = 5,
    parameter logic [AW-1:0] HANDLER_PC = 32'h0000_0020,
    parameter logic [AW-1:0] BREAK_PC   = 32'h0000_0120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        evt_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [IDXW-1:0]   ctl_idx_i,
    output logic [DW-1:0]     rd_data_o,
    output logic [STAT_W-1:0] status_o,
    output logic              redirect_o,
    output logic [AW-1:0]     redirect_pc_o
);
    exc_evt_e          evt;
    logic              is_trap, is_brk, is_eret, is_bret, is_wr;
    logic [STAT_W-1:0] stat_q, estat_q, bstat_q;
    logic [AW-1:0]     ea_q, ba_q;

    // Decode the event code into one-hot flags; unknown codes decode to none.
    always_comb begin
        evt     = exc_evt_e'(evt_i);
        is_trap = (evt == EV_TRAP);
        is_brk  = (evt == EV_BRK);
        is_eret = (evt == EV_ERET);
        is_bret = (evt == EV_BRET);
        is_wr   = (evt == EV_WRCTL);
    end

    exc_status_regs #(.IDXW(IDXW)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .is_trap(is_trap), .is_brk(is_brk), .is_eret(is_eret), .is_bret(is_bret),
        .wr_en(is_wr), .wr_idx(ctl_idx_i), .wr_val(wr_data_i[STAT_W-1:0]),
        .stat_q(stat_q), .estat_q(estat_q), .bstat_q(bstat_q)
    );

    exc_return_regs #(.AW(AW)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .is_trap(is_trap), .is_brk(is_brk), .pc_i(pc_i),
        .ea_q(ea_q), .ba_q(ba_q)
    );

    exc_redirect #(.AW(AW), .HANDLER_PC(HANDLER_PC), .BREAK_PC(BREAK_PC)) u_redir (
        .clk(clk), .rst_n(rst_n),
        .is_trap(is_trap), .is_brk(is_brk), .is_eret(is_eret), .is_bret(is_bret),
        .ea_q(ea_q), .ba_q(ba_q),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    exc_ctl_read #(.DW(DW), .IDXW(IDXW)) u_rd (
        .idx(ctl_idx_i), .stat_q(stat_q), .estat_q(estat_q), .bstat_q(bstat_q),
        .rd_data(rd_data_o)
    );

    // Expose the live status word.
    always_comb status_o = stat_q;
endmodule

// File: rtl/exc_ctl_checker.sv
// Temporal checks for the exception and control-register unit, bound to the top.
module exc_ctl_checker #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    evt_i,
    input logic [1:0]    status_o,
    input logic [1:0]    estat,
    input logic [1:0]    bstat,
    input logic          redirect_o,
    input logic [DW-1:0] rd_data_o
);
    logic flow_evt;
    always_comb flow_evt = (evt_i >= 3'd1) && (evt_i <= 3'd4);

    a_r2_trap_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == 3'd1) |=> (estat == $past(status_o)) && (status_o == 2'b00));

    a_r3_break_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == 3'd2) |=> (bstat == $past(status_o)) && (status_o == 2'b00));

    a_r4_eret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == 3'd3) |=> (status_o == $past(estat)));

    a_r5_bret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == 3'd4) |=> (status_o == $past(bstat)));

    a_r8_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_evt) |=> !redirect_o);

    a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        flow_evt |=> redirect_o);

    a_r10_ignored_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == 3'd0 || evt_i >= 3'd6) |=>
            ($stable(status_o) && $stable(estat) && $stable(bstat)));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DW-1:2] == '0);
endmodule

bind exc_ctl_unit exc_ctl_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .status_o(status_o),
    .estat(estat_q), .bstat(bstat_q), .redirect_o(redirect_o),
    .rd_data_o(rd_data_o)
);

// File: tb/sim_exc_ctl_unit.sv
`timescale 1ns/1ps
module sim_exc_ctl_unit;
    localparam logic [31:0] HPC = 32'h0000_0020;
    localparam logic [31:0] BPC = 32'h0000_0120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_i = 3'd0;
    logic [31:0] pc_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [4:0]  ctl_idx_i = '0;
    logic [31:0] rd_data_o;
    logic [1:0]  status_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;

    int checks = 0;
    int fails  = 0;

    logic [1:0]  m_stat = 2'b00, m_est = 2'b00, m_bst = 2'b00;
    logic [31:0] m_ea = '0, m_ba = '0;

    always #5 clk = ~clk;

    exc_ctl_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .pc_i(pc_i),
        .wr_data_i(wr_data_i), .ctl_idx_i(ctl_idx_i), .rd_data_o(rd_data_o),
        .status_o(status_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input int idx);
        case (idx)
            0: return {30'd0, m_stat};
            1: return {30'd0, m_est};
            2: return {30'd0, m_bst};
            default: return 32'd0;
        endcase
    endfunction

    // Compare the live status and several read indices with the model.
    task automatic check_state(input string req);
        chk(req, "status_o", {30'd0, status_o}, {30'd0, m_stat});
        for (int i = 0; i < 4; i++) begin
            ctl_idx_i = 5'(i);
            #1;
            chk(req, $sformatf("rd idx %0d", i), rd_data_o, model_rd(i));
        end
        ctl_idx_i = 5'd31;
        #1;
        chk(req, "rd idx 31", rd_data_o, 32'd0);
    endtask

    // Present one event, wait one edge, update the model and check.
    task automatic step(input logic [2:0] ev, input logic [31:0] pc,
                        input logic [31:0] wd, input logic [4:0] idx,
                        input string req);
        logic        exp_r;
        logic [31:0] exp_pc;
        evt_i = ev; pc_i = pc; wr_data_i = wd; ctl_idx_i = idx;
        @(posedge clk);
        #1;
        evt_i = 3'd0;
        exp_r = 1'b0; exp_pc = '0;
        case (ev)
            3'd1: begin exp_r = 1; exp_pc = HPC; m_est = m_stat; m_stat = 2'b00; m_ea = pc + 4; end
            3'd2: begin exp_r = 1; exp_pc = BPC; m_bst = m_stat; m_stat = 2'b00; m_ba = pc + 4; end
            3'd3: begin exp_r = 1; exp_pc = m_ea; m_stat = m_est; end
            3'd4: begin exp_r = 1; exp_pc = m_ba; m_stat = m_bst; end
            3'd5: begin
                if (idx == 5'd0) m_stat = wd[1:0];
                else if (idx == 5'd1) m_est = wd[1:0];
                else if (idx == 5'd2) m_bst = wd[1:0];
            end
            default: ;
        endcase
        chk(req, "redirect_o", {31'd0, redirect_o}, {31'd0, exp_r});
        if (exp_r) chk(req, "redirect_pc_o", redirect_pc_o, exp_pc);
        check_state(req);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "redirect_o", {31'd0, redirect_o}, 32'd0);
        check_state("R1");
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R7 / R6: write sweep over indices and status values, upper bits set
        for (int idx = 0; idx < 8; idx++)
            for (int v = 0; v < 4; v++)
                step(3'd5, 32'h0, 32'hA5A5_A5A0 | 32'(v), 5'(idx), "R7");

        // R2 / R4 and R3 / R5 for every starting status value
        for (int s = 0; s < 4; s++) begin
            step(3'd5, 32'h0, 32'(s), 5'd0, "R7");
            step(3'd1, 32'h0000_1000 + 32'(s * 16), 32'h0, 5'd0, "R2");
            step(3'd3, 32'h0, 32'h0, 5'd0, "R4");
            chk("R4", "status restored", {30'd0, status_o}, 32'(s));
            step(3'd2, 32'h0000_2000 + 32'(s * 16), 32'h0, 5'd0, "R3");
            step(3'd4, 32'h0, 32'h0, 5'd0, "R5");
            chk("R5", "status restored", {30'd0, status_o}, 32'(s));
        end

        // R9: trap, write user mode, break, then unwind in order
        step(3'd5, 32'h0, 32'h3, 5'd0, "R9");
        step(3'd1, 32'h0000_0400, 32'h0, 5'd0, "R9");
        step(3'd5, 32'h0, 32'h2, 5'd0, "R9");
        step(3'd2, 32'h0000_0500, 32'h0, 5'd0, "R9");
        step(3'd4, 32'h0, 32'h0, 5'd0, "R9");
        chk("R9", "after break return", {30'd0, status_o}, 32'h2);
        step(3'd3, 32'h0, 32'h0, 5'd0, "R9");
        chk("R9", "after exception return", {30'd0, status_o}, 32'h3);

        // R2 corner: back-to-back traps leave a cleared shadow
        step(3'd1, 32'h0000_0600, 32'h0, 5'd0, "R2");
        step(3'd1, 32'h0000_0700, 32'h0, 5'd0, "R2");
        step(3'd3, 32'h0, 32'h0, 5'd0, "R4");

        // R10 / R8: set distinct state, then ignored codes
        step(3'd5, 32'h0, 32'h1, 5'd0, "R10");
        step(3'd5, 32'h0, 32'h2, 5'd1, "R10");
        step(3'd5, 32'h0, 32'h3, 5'd2, "R10");
        step(3'd0, 32'h0000_0800, 32'h3, 5'd0, "R10");
        step(3'd6, 32'h0000_0800, 32'h0, 5'd0, "R10");
        step(3'd7, 32'h0000_0800, 32'h0, 5'd1, "R10");
        // R8: strobe drops after one cycle
        step(3'd1, 32'h0000_0900, 32'h0, 5'd0, "R8");
        step(3'd0, 32'h0, 32'h0, 5'd0, "R8");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule